// File: doc/BRIEF.md
# APB Countdown Timer

A single timer channel on an APB slave port. A counter of CNT_W bits (32 by default) counts down by one on every clock while it is enabled. When it reaches zero, it reloads on the next clock. The reload value depends on the mode. In periodic mode it reloads the programmed start value, which gives a steady tick. In free-running mode it reloads all ones, so the counter spans its full range before the next event.

Reaching zero latches a pending event that software can see in two forms, raw or masked. The masked form drives the interrupt line. Software acknowledges the event by reading an acknowledge address; a write does nothing there. Software can also read the live count at any time, which lets the block serve as a time base.

Top module: `apb_countdown_timer`

## Requirements
- R1: After an active-low reset, every register reads 0 and the irq output is 0. The only exception is the version word at 0xAC.
- R2: A control write at offset 0x08 that sets bit 0 while counting is off copies the start value into the counter. From the next clock the counter drops by one per clock. Offset 0x04 returns the live count.
- R3: While control bit 0 is 0, the count holds its value. The control word reads back at 0x08 in bits [2:0] with zeros above, and turning counting off leaves bits 1 and 2 unchanged.
- R4: With control bit 1 = 0 (free-running), a count of 0 becomes all ones on the next enabled clock.
- R5: With control bit 1 = 1 (periodic), a count of 0 becomes the start value (offset 0x00) on the next enabled clock.
- R6: On that wrap, the pending flag sets whatever the mask is. Offset 0xA8 returns the flag in bit 0. Offsets 0x10 and 0xA0 return the flag AND NOT control bit 2 (1 = masked).
- R7: The irq output equals the masked flag. The flag stays set until it is acknowledged.
- R8: An APB read of 0x0C or of 0xA4 clears the flag, and the read itself returns 0. A wrap in the same cycle takes priority and leaves the flag set.
- R9: A write to 0x00 takes effect only while counting is off. Writes to 0x04, 0x0C, 0x10, 0xA0, 0xA4, 0xA8, 0xAC and to unmapped offsets change nothing.
- R10: A read of an unmapped offset returns 0, and 0xAC returns the VERSION parameter. pready is always 1 and pslverr is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Clock |
| presetn | input | 1 | Active-low reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | ADDR_W | Byte offset |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data |
| pready | output | 1 | Always 1 |
| pslverr | output | 1 | Always 0 |
| irq | output | 1 | Masked pending event |

## Verification
Directed sequences cover the two reload modes separately. Each one reads the count just after a wrap, which shows whether the counter reloaded all ones or the start value. A masked run shows that the raw flag sets while the irq line stays low. A read of each acknowledge address clears the flag, which separates acknowledge-on-read from acknowledge-on-write. A write to the start value while counting, and writes to read-only offsets, are each followed by a read-back that shows nothing changed. After these, a long seeded random mix of start values, control words, reads and idle gaps keeps wraps, acknowledges and mode changes colliding in many orders. Every read and every cycle of the irq line is compared against a cycle model in the bench.

// File: rtl/apb_countdown_timer.sv
module apb_countdown_timer #(
  parameter int          ADDR_W  = 8,
  parameter int          CNT_W   = 32,
  parameter logic [31:0] VERSION = 32'h0001_0200
) (
  input  logic              pclk,
  input  logic              presetn,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [31:0]       pwdata,
  output logic [31:0]       prdata,
  output logic              pready,
  output logic              pslverr,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] A_START = ADDR_W'('h00);
  localparam logic [ADDR_W-1:0] A_COUNT = ADDR_W'('h04);
  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'('h08);
  localparam logic [ADDR_W-1:0] A_ACK   = ADDR_W'('h0C);
  localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'('h10);
  localparam logic [ADDR_W-1:0] A_GSTAT = ADDR_W'('hA0);
  localparam logic [ADDR_W-1:0] A_GACK  = ADDR_W'('hA4);
  localparam logic [ADDR_W-1:0] A_GRAW  = ADDR_W'('hA8);
  localparam logic [ADDR_W-1:0] A_VER   = ADDR_W'('hAC);

  logic [CNT_W-1:0] start_q, cnt_q;
  logic [2:0]       ctrl_q;
  logic             flag_q;

  wire run      = ctrl_q[0];
  wire periodic = ctrl_q[1];
  wire masked   = ctrl_q[2];
  wire acc      = psel & penable;
  wire wr       = acc & pwrite;
  wire rd       = acc & ~pwrite;
  wire wr_ctrl  = wr & (paddr == A_CTRL);
  wire wr_start = wr & (paddr == A_START) & ~run;
  wire ack_rd   = rd & ((paddr == A_ACK) | (paddr == A_GACK));
  wire wrap     = run & (cnt_q == '0);
  wire kick     = wr_ctrl & ~run & pwdata[0];
  wire shown    = flag_q & ~masked;

  assign pready  = 1'b1;
  assign pslverr = 1'b0;
  assign irq     = shown;

  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn) begin
      start_q <= '0;
      cnt_q   <= '0;
      ctrl_q  <= '0;
      flag_q  <= 1'b0;
    end else begin
      if (wr_start) start_q <= pwdata[CNT_W-1:0];
      if (wr_ctrl)  ctrl_q  <= pwdata[2:0];
      if (kick)
        cnt_q <= start_q;
      else if (run)
        cnt_q <= wrap ? (periodic ? start_q : {CNT_W{1'b1}}) : cnt_q - 1'b1;
      if (wrap)        flag_q <= 1'b1;
      else if (ack_rd) flag_q <= 1'b0;
    end
  end

  always_comb begin
    prdata = '0;
    if (!pwrite)
      case (paddr)
        A_START: prdata = 32'(start_q);
        A_COUNT: prdata = 32'(cnt_q);
        A_CTRL:  prdata = {29'd0, ctrl_q};
        A_STAT,
        A_GSTAT: prdata = {31'd0, shown};
        A_GRAW:  prdata = {31'd0, flag_q};
        A_VER:   prdata = VERSION;
        default: prdata = '0;
      endcase
  end

  assert_hold_off_R3: assert property (@(posedge pclk) disable iff (!presetn)
    (!run && !wr_ctrl) |=> $stable(cnt_q));
  assert_free_reload_R4: assert property (@(posedge pclk) disable iff (!presetn)
    (wrap && !periodic && !wr_ctrl) |=> (cnt_q == {CNT_W{1'b1}}));
  assert_periodic_reload_R5: assert property (@(posedge pclk) disable iff (!presetn)
    (wrap && periodic && !wr_ctrl) |=> (cnt_q == $past(start_q)));
  assert_flag_on_wrap_R6: assert property (@(posedge pclk) disable iff (!presetn)
    wrap |=> flag_q);
  assert_flag_sticky_R7: assert property (@(posedge pclk) disable iff (!presetn)
    (flag_q && !ack_rd) |=> flag_q);
  assert_ack_clears_R8: assert property (@(posedge pclk) disable iff (!presetn)
    (ack_rd && !wrap) |=> !flag_q);
  assert_start_locked_R9: assert property (@(posedge pclk) disable iff (!presetn)
    run |=> $stable(start_q));
endmodule

// File: tb/apb_countdown_timer_test.sv
module apb_countdown_timer_test;
  logic        pclk = 0, presetn = 0;
  logic        psel = 0, penable = 0, pwrite = 0;
  logic [7:0]  paddr = 0;
  logic [31:0] pwdata = 0, prdata;
  logic        pready, pslverr, irq;
  localparam logic [31:0] VER = 32'h0001_0200;

  apb_countdown_timer uut (.pclk, .presetn, .psel, .penable, .pwrite, .paddr,
    .pwdata, .prdata, .pready, .pslverr, .irq);

  always #2.5 pclk = ~pclk;

  int checks = 0, fails = 0, cycles = 0;
  bit live = 0;
  logic [31:0] m_start, m_cnt;
  logic [2:0]  m_ctrl;
  logic        m_flag;

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [31:0] exp_rd(logic [7:0] a);
    case (a)
      8'h00: return m_start;
      8'h04: return m_cnt;
      8'h08: return {29'd0, m_ctrl};
      8'h10, 8'hA0: return {31'd0, m_flag & ~m_ctrl[2]};
      8'hA8: return {31'd0, m_flag};
      8'hAC: return VER;
      default: return 32'd0;
    endcase
  endfunction

  function automatic string tag_of(logic [7:0] a);
    case (a)
      8'h00: return "R9 start";
      8'h04: return "R2 count";
      8'h08: return "R3 ctrl";
      8'h10, 8'hA0, 8'hA8: return "R6 status";
      8'h0C, 8'hA4: return "R8 ack";
      8'hAC: return "R10 version";
      default: return "R10 unmapped";
    endcase
  endfunction

  always @(posedge pclk or negedge presetn) begin
    if (!presetn) begin
      m_start = 0; m_cnt = 0; m_ctrl = 0; m_flag = 0;
    end else begin
      logic [31:0] nc; logic [2:0] nctl; logic [31:0] ns; logic nf, w;
      nc = m_cnt; nctl = m_ctrl; ns = m_start; nf = m_flag;
      w = m_ctrl[0] && m_cnt == 0;
      if (m_ctrl[0]) nc = w ? (m_ctrl[1] ? m_start : 32'hFFFF_FFFF) : m_cnt - 1;
      if (psel && penable && !pwrite && (paddr == 8'h0C || paddr == 8'hA4)) nf = 0;
      if (w) nf = 1;
      if (psel && penable && pwrite && paddr == 8'h00 && !m_ctrl[0]) ns = pwdata;
      if (psel && penable && pwrite && paddr == 8'h08) begin
        nctl = pwdata[2:0];
        if (!m_ctrl[0] && pwdata[0]) nc = m_start;
      end
      m_cnt = nc; m_ctrl = nctl; m_start = ns; m_flag = nf;
    end
  end

  always @(negedge pclk) if (live) begin
    chk("R7 irq", {31'd0, irq}, {31'd0, m_flag & ~m_ctrl[2]});
    chk("R10 ready/err", {30'd0, pready, pslverr}, 32'h2);
  end

  task automatic xfer(bit w, logic [7:0] a, logic [31:0] d, output logic [31:0] r);
    @(negedge pclk); psel = 1; penable = 0; pwrite = w; paddr = a; pwdata = d;
    @(negedge pclk); penable = 1; #1; r = prdata;
    @(negedge pclk); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    logic [31:0] r; xfer(1, a, d, r);
  endtask

  task automatic rd(logic [7:0] a);
    logic [31:0] r, e;
    @(negedge pclk); psel = 1; penable = 0; pwrite = 0; paddr = a;
    @(negedge pclk); penable = 1; #1; r = prdata; e = exp_rd(a);
    chk(tag_of(a), r, e);
    @(negedge pclk); psel = 0; penable = 0;
  endtask

  task automatic rd_get(logic [7:0] a, output logic [31:0] r);
    xfer(0, a, 0, r);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge pclk);
  endtask

  initial begin
    while (1) begin
      @(posedge pclk); cycles++;
      if (cycles > 150000) begin
        fails++; checks++;
        $display("FAIL watchdog: got %0d cycles expected fewer", cycles);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd1234));
    repeat (3) @(negedge pclk);
    presetn = 1; live = 1;
    // R1 reset state
    foreach (v[i]) if (i < 1) begin end
    for (int a = 0; a < 8'hB0; a += 4) begin
      rd_get(a[7:0], v);
      chk("R1 reset", v, (a == 8'hAC) ? VER : 32'd0);
    end
    chk("R1 irq", {31'd0, irq}, 32'd0);

    // R4 free-running wrap
    wr(8'h00, 32'd3); wr(8'h08, 32'h1);
    idle(6); rd_get(8'h04, v);
    chk("R4 free reload", {31'd0, v > 32'hFFFF_FF00}, 32'd1);
    rd(8'hA8); rd(8'h10);
    chk("R7 irq high", {31'd0, irq}, 32'd1);
    idle(4);
    chk("R7 irq held", {31'd0, irq}, 32'd1);
    rd(8'h0C); rd(8'hA8);
    chk("R8 cleared", {31'd0, irq}, 32'd0);

    // R9 start locked while running
    wr(8'h00, 32'd77); rd(8'h00);
    chk("R9 start kept", m_start, 32'd3);
    // R3 stop keeps bits
    wr(8'h08, 32'h7); rd(8'h08);
    wr(8'h08, 32'h6); rd(8'h04); idle(3); rd(8'h04); rd(8'h08);

    // R5 periodic, masked: R6 raw sets, irq low
    wr(8'h00, 32'd5); wr(8'h08, 32'h7);
    idle(8); rd(8'h04); rd(8'hA8); rd(8'hA0);
    chk("R6 masked irq", {31'd0, irq}, 32'd0);
    rd_get(8'h04, v);
    chk("R5 periodic bound", {31'd0, v <= 32'd5}, 32'd1);
    rd(8'hA4); rd(8'hA8);

    // read-only / unmapped writes ignored
    wr(8'h04, 32'hDEAD); wr(8'hAC, 32'h1); wr(8'hA8, 32'h1); wr(8'h44, 32'h1);
    rd(8'h04); rd(8'hAC); rd(8'h44); rd(8'hA8);
    wr(8'h08, 32'h0); rd(8'h04); rd(8'h08);

    // R2 start with zero value in periodic mode: wraps each cycle
    wr(8'h00, 32'd0); wr(8'h08, 32'h3); idle(2); rd(8'h0C); rd(8'hA8);
    wr(8'h08, 32'h0);

    // random mix
    for (int n = 0; n < 4000; n++) begin
      int k = $urandom_range(0, 9);
      case (k)
        0: wr(8'h00, $urandom_range(0, 24));
        1: wr(8'h08, $urandom_range(0, 7));
        2: begin
             int s = $urandom_range(0, 12);
             logic [7:0] a = (s == 12) ? 8'(4 * $urandom_range(0, 63)) :
               8'(s < 5 ? 4 * s : 8'hA0 + 4 * (s - 5));
             wr(a, $urandom);
           end
        3, 4, 5, 6: begin
             int s = $urandom_range(0, 10);
             logic [7:0] a = (s == 10) ? 8'(4 * $urandom_range(0, 63)) :
               8'(s < 5 ? 4 * s : 8'hA0 + 4 * (s - 5 > 3 ? 3 : s - 5));
             rd(a);
           end
        default: idle($urandom_range(0, 6));
      endcase
    end

    live = 0;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule